// File: doc/BRIEF.md
# Audio Serial Transmit Port

This block is the playback half of an audio serial port. A bus master or DMA engine writes samples into a transmit FIFO. The block then shifts each sample out, MSB first, on a single serial data line. The bit-clock falling edges and the frame-sync level come from outside the block. The falling edges arrive as one-cycle strobes in the system clock domain. A frame holds two 32-bit channel slots. The left slot is sent while frame sync is low, and a new slot starts on every strobe at which frame sync has changed level. The block supports standard I2S framing, where the MSB trails the slot start by one bit clock, and MSB-justified framing, where the MSB is sent on the slot-start bit clock.

The configuration inputs set:
- the sample width: 8 or 16 bits;
- mono duplication, which sends one FIFO entry on both channels;
- the FIFO level at which service is requested;
- what is sent when the FIFO is empty: zeros or a replay of the previous sample;
- a flush that empties the FIFO.

The DMA request and the service interrupt are driven from the FIFO level. A sticky underrun flag records a slot that found no data, and it can raise its own interrupt.

Top module: `i2s_tx_port`

## Requirements
- R1: A write is accepted when the FIFO is not full and no flush is applied in that cycle. `fifo_level_o` then rises by one on the next clock. A write to a full FIFO is dropped, and the level stays at DEPTH.
- R2: A flush empties the FIFO so that the level reads 0 on the next clock. It also clears the underrun flag and the replay sample. A write in the same cycle as a flush is discarded.
- R3: `dma_req_o` is high exactly when `cfg_dma_en_i` is 1 and the FIFO level is at or below `cfg_thresh_i`. `svc_irq_o` follows the same level rule, gated by `cfg_svc_ie_i`.
- R4: A slot starts on a strobe at which `fsync_i` differs from its value at the previous strobe. It is the left slot when `fsync_i` is 0. With `cfg_lj_i`=1, slot bit k (k=0..31) is sent as word bit 31-k. With `cfg_lj_i`=0, slot bit 0 is 0 and slot bit k is sent as word bit 32-k. All word bits below the sample are 0.
- R5: With `cfg_size_i`=0, the word holds entry bits [7:0] in word bits [31:24]. With any other code, it holds entry bits [15:0] in word bits [31:16].
- R6: In stereo (`cfg_mono_i`=0), every slot start pops one entry, left slot first.
- R7: In mono (`cfg_mono_i`=1), only the left slot pops an entry, and the right slot repeats the word sent in the left slot.
- R8: A slot that needs an entry but finds the FIFO empty sets the sticky underrun flag. It sends the last popped entry if `cfg_replay_i`=1, and zero otherwise.
- R9: `urun_irq_o` equals the underrun flag gated by `cfg_urun_ie_i`.
- R10: Unless both `cfg_enable_i` and `cfg_play_i` are 1, the FIFO is never popped, no underrun is flagged, and `sdo_o` is 0 after every strobe.
- R11: `sdo_o` changes only on clocks at which `bclk_fall_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write one sample into the FIFO |
| wr_data_i | input | DATA_W | Sample data |
| cfg_enable_i | input | 1 | Global port enable |
| cfg_play_i | input | 1 | Playback enable |
| cfg_dma_en_i | input | 1 | Allows the DMA request |
| cfg_size_i | input | 3 | Sample width code (0: 8-bit, else 16-bit) |
| cfg_mono_i | input | 1 | Send each entry on both channels |
| cfg_flush_i | input | 1 | Empty the FIFO |
| cfg_thresh_i | input | THR_W | Service level threshold |
| cfg_replay_i | input | 1 | On underrun, repeat the last sample |
| cfg_lj_i | input | 1 | 1: MSB-justified, 0: I2S framing |
| cfg_svc_ie_i | input | 1 | Service interrupt enable |
| cfg_urun_ie_i | input | 1 | Underrun interrupt enable |
| bclk_fall_i | input | 1 | Strobe marking a bit-clock falling edge |
| fsync_i | input | 1 | Frame sync level (0 = left) |
| sdo_o | output | 1 | Serial data out |
| dma_req_o | output | 1 | DMA service request |
| svc_irq_o | output | 1 | FIFO service interrupt |
| urun_flag_o | output | 1 | Sticky underrun flag |
| urun_irq_o | output | 1 | Underrun interrupt |
| fifo_level_o | output | LVL_W | Current FIFO fill level |

## Verification
The bench uses the default parameters: 16-bit entries, a 16-deep FIFO, 32-bit slots and a 4-bit threshold. At this size the bench can walk every fill level from empty to full against every one of the 16 threshold codes. It also sweeps all sixteen combinations of framing, sample width, mono duplication and replay. Each combination runs three complete frames and is checked bit by bit against words computed arithmetically. Every combination is given too few samples, so each one runs into underrun and covers both replay policies.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

   // framing select carried on cfg_lj_i
   typedef enum logic {
      FRAME_I2S = 1'b0,
      FRAME_LJ  = 1'b1
   } frame_e;

   // sample width codes; every code other than SZ_BYTE is treated as full width
   localparam logic [2:0] SZ_BYTE = 3'd0;
   localparam logic [2:0] SZ_HALF = 3'd1;

   // per-slot decision taken at a slot start
   typedef struct packed {
      logic need;   // slot wants a new FIFO entry
      logic pop;    // entry available and taken
      logic urun;   // entry wanted but FIFO empty
   } slot_act_t;

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
   parameter  int DATA_W = 16,
   parameter  int DEPTH  = 16,
   localparam int LVL_W  = $clog2(DEPTH + 1),
   localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              push_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] data_o,
   output logic [LVL_W-1:0]  level_o,
   output logic              empty_o,
   output logic              full_o
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("i2s_tx_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr, wptr_nx, rptr_nx;
   logic [LVL_W-1:0]  cnt;
   logic              do_push, do_pop;

   assign empty_o = (cnt == '0);
   assign full_o  = (cnt == LVL_W'(DEPTH));
   assign do_push = push_i & ~full_o & ~flush_i;
   assign do_pop  = pop_i & ~empty_o & ~flush_i;
   assign data_o  = mem[rptr];
   assign level_o = cnt;

   // pointer advance: free wrap for power-of-two depths, compare otherwise
   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_mod
         assign wptr_nx = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (flush_i) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

endmodule

// File: rtl/i2s_tx_fmt.sv
module i2s_tx_fmt
   import i2s_tx_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SLOT_W = 32
) (
   input  logic [DATA_W-1:0] sample_i,
   input  logic [2:0]        size_i,
   output logic [SLOT_W-1:0] word_o
);

   generate
      if (DATA_W < 8 || SLOT_W <= 8 || SLOT_W < DATA_W) begin : g_bad_width
         $error("i2s_tx_fmt: need 8 <= DATA_W <= SLOT_W and SLOT_W > 8");
      end
   endgenerate

   logic [SLOT_W-1:0] narrow, wide;

   assign narrow = {sample_i[7:0], {(SLOT_W - 8){1'b0}}};

   // a zero-width pad is illegal, so full-slot samples take their own branch
   generate
      if (SLOT_W == DATA_W) begin : g_full
         assign wide = sample_i;
      end else begin : g_pad
         assign wide = {sample_i, {(SLOT_W - DATA_W){1'b0}}};
      end
   endgenerate

   assign word_o = (size_i == SZ_BYTE) ? narrow : wide;

endmodule

// File: rtl/i2s_tx_slot_sel.sv
module i2s_tx_slot_sel
   import i2s_tx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              slot_start_i,
   input  logic              left_i,
   input  logic              active_i,
   input  logic              mono_i,
   input  logic              replay_i,
   input  logic              empty_i,
   input  logic [DATA_W-1:0] head_i,
   output logic              pop_o,
   output logic              urun_o,
   output logic [DATA_W-1:0] sample_o
);

   slot_act_t         act;
   logic [DATA_W-1:0] cur_q;   // sample of the slot in progress
   logic [DATA_W-1:0] last_q;  // most recently popped entry

   always_comb begin
      act.need = slot_start_i & active_i & (left_i | ~mono_i);
      act.pop  = act.need & ~empty_i;
      act.urun = act.need & empty_i;
   end

   assign pop_o  = act.pop;
   assign urun_o = act.urun;

   always_comb begin
      if (!act.need)     sample_o = cur_q;
      else if (act.pop)  sample_o = head_i;
      else if (replay_i) sample_o = last_q;
      else               sample_o = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         last_q <= '0;
      end else if (flush_i) begin
         cur_q  <= '0;
         last_q <= '0;
      end else begin
         if (slot_start_i && active_i) cur_q <= sample_o;
         if (act.pop) last_q <= head_i;
      end
   end

endmodule

// File: rtl/i2s_tx_serdes.sv
module i2s_tx_serdes
   import i2s_tx_pkg::*;
#(
   parameter int SLOT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_fall_i,
   input  logic              fsync_i,
   input  logic              active_i,
   input  logic              lj_i,
   input  logic [SLOT_W-1:0] word_i,
   output logic              slot_start_o,
   output logic              left_o,
   output logic              sdo_o
);

   logic              fs_q;
   logic [SLOT_W-1:0] sh_q;
   frame_e            frame;

   assign frame        = frame_e'(lj_i);
   assign slot_start_o = bclk_fall_i & (fsync_i != fs_q);
   assign left_o       = ~fsync_i;

   // fs_q resets high so the first strobe with sync low opens a left slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q  <= 1'b1;
         sh_q  <= '0;
         sdo_o <= 1'b0;
      end else if (bclk_fall_i) begin
         fs_q <= fsync_i;
         if (!active_i) begin
            sh_q  <= '0;
            sdo_o <= 1'b0;
         end else if (slot_start_o) begin
            if (frame == FRAME_LJ) begin
               sdo_o <= word_i[SLOT_W-1];
               sh_q  <= {word_i[SLOT_W-2:0], 1'b0};
            end else begin
               sdo_o <= 1'b0;
               sh_q  <= word_i;
            end
         end else begin
            sdo_o <= sh_q[SLOT_W-1];
            sh_q  <= {sh_q[SLOT_W-2:0], 1'b0};
         end
      end
   end

endmodule

// File: rtl/i2s_tx_port.sv
module i2s_tx_port
   import i2s_tx_pkg::*;
#(
   parameter  int DATA_W = 16,
   parameter  int DEPTH  = 16,
   parameter  int SLOT_W = 32,
   parameter  int THR_W  = 4,
   localparam int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              cfg_enable_i,
   input  logic              cfg_play_i,
   input  logic              cfg_dma_en_i,
   input  logic [2:0]        cfg_size_i,
   input  logic              cfg_mono_i,
   input  logic              cfg_flush_i,
   input  logic [THR_W-1:0]  cfg_thresh_i,
   input  logic              cfg_replay_i,
   input  logic              cfg_lj_i,
   input  logic              cfg_svc_ie_i,
   input  logic              cfg_urun_ie_i,
   input  logic              bclk_fall_i,
   input  logic              fsync_i,
   output logic              sdo_o,
   output logic              dma_req_o,
   output logic              svc_irq_o,
   output logic              urun_flag_o,
   output logic              urun_irq_o,
   output logic [LVL_W-1:0]  fifo_level_o
);

   generate
      if (THR_W < 1 || THR_W > 16) begin : g_bad_thr
         $error("i2s_tx_port: THR_W out of range");
      end
   endgenerate

   logic              active;
   logic              fifo_empty, fifo_full;
   logic [DATA_W-1:0] fifo_head;
   logic              pop, urun_evt;
   logic              slot_start, slot_left;
   logic [DATA_W-1:0] slot_sample;
   logic [SLOT_W-1:0] slot_word;
   logic              at_thresh;
   logic              urun_q;

   assign active = cfg_enable_i & cfg_play_i;

   i2s_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (cfg_flush_i),
      .push_i  (wr_en_i),
      .data_i  (wr_data_i),
      .pop_i   (pop),
      .data_o  (fifo_head),
      .level_o (fifo_level_o),
      .empty_o (fifo_empty),
      .full_o  (fifo_full)
   );

   i2s_tx_slot_sel #(.DATA_W(DATA_W)) u_sel (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_i      (cfg_flush_i),
      .slot_start_i (slot_start),
      .left_i       (slot_left),
      .active_i     (active),
      .mono_i       (cfg_mono_i),
      .replay_i     (cfg_replay_i),
      .empty_i      (fifo_empty),
      .head_i       (fifo_head),
      .pop_o        (pop),
      .urun_o       (urun_evt),
      .sample_o     (slot_sample)
   );

   i2s_tx_fmt #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_fmt (
      .sample_i (slot_sample),
      .size_i   (cfg_size_i),
      .word_o   (slot_word)
   );

   i2s_tx_serdes #(.SLOT_W(SLOT_W)) u_ser (
      .clk          (clk),
      .rst_n        (rst_n),
      .bclk_fall_i  (bclk_fall_i),
      .fsync_i      (fsync_i),
      .active_i     (active),
      .lj_i         (cfg_lj_i),
      .word_i       (slot_word),
      .slot_start_o (slot_start),
      .left_o       (slot_left),
      .sdo_o        (sdo_o)
   );

   // level and threshold compared at a common 32-bit width
   assign at_thresh = (32'(fifo_level_o) <= 32'(cfg_thresh_i));
   assign dma_req_o = cfg_dma_en_i & at_thresh;
   assign svc_irq_o = cfg_svc_ie_i & at_thresh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           urun_q <= 1'b0;
      else if (cfg_flush_i) urun_q <= 1'b0;
      else if (urun_evt)    urun_q <= 1'b1;
   end

   assign urun_flag_o = urun_q;
   assign urun_irq_o  = urun_q & cfg_urun_ie_i;

   // fifo_full feeds only the FIFO's own write gate
   logic unused_full;
   assign unused_full = fifo_full;

endmodule

// File: rtl/i2s_tx_port_chk.sv
module i2s_tx_port_chk #(
   parameter int DEPTH = 16,
   parameter int LVL_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_enable_i,
   input logic             cfg_play_i,
   input logic             cfg_dma_en_i,
   input logic             cfg_flush_i,
   input logic             bclk_fall_i,
   input logic             sdo_o,
   input logic             dma_req_o,
   input logic             urun_flag_o,
   input logic             urun_irq_o,
   input logic [LVL_W-1:0] fifo_level_o
);

   // R1
   no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level_o <= LVL_W'(DEPTH));

   // R2
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_flush_i |=> (fifo_level_o == '0 && !urun_flag_o));

   // R3
   dma_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req_o |-> cfg_dma_en_i);

   // R8
   urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (urun_flag_o && !cfg_flush_i) |=> urun_flag_o);

   // R9
   urun_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      urun_irq_o |-> urun_flag_o);

   // R10
   idle_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cfg_enable_i && cfg_play_i) && !cfg_flush_i) |=> fifo_level_o >= $past(fifo_level_o));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bclk_fall_i && !(cfg_enable_i && cfg_play_i)) |=> !sdo_o);

   // R11
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bclk_fall_i |=> $stable(sdo_o));

endmodule

bind i2s_tx_port i2s_tx_port_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_enable_i (cfg_enable_i),
   .cfg_play_i   (cfg_play_i),
   .cfg_dma_en_i (cfg_dma_en_i),
   .cfg_flush_i  (cfg_flush_i),
   .bclk_fall_i  (bclk_fall_i),
   .sdo_o        (sdo_o),
   .dma_req_o    (dma_req_o),
   .urun_flag_o  (urun_flag_o),
   .urun_irq_o   (urun_irq_o),
   .fifo_level_o (fifo_level_o)
);

// File: tb/test_i2s_tx_port.sv
`timescale 1ns/1ps
module test_i2s_tx_port;

   localparam int DATA_W = 16;
   localparam int DEPTH  = 16;
   localparam int SLOT_W = 32;
   localparam int THR_W  = 4;
   localparam int LVL_W  = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              en = 1'b0, play = 1'b0, dma_en = 1'b0, mono = 1'b0;
   logic [2:0]        size = 3'd1;
   logic              flush = 1'b0, replay = 1'b0, lj = 1'b0;
   logic [THR_W-1:0]  thr = '0;
   logic              svc_ie = 1'b0, urun_ie = 1'b0;
   logic              bfall = 1'b0, fsync = 1'b0;
   logic              sdo, dma_req, svc_irq, urun_flag, urun_irq;
   logic [LVL_W-1:0]  level;

   int total = 0;
   int bad   = 0;
   int n_fall = 0;
   bit done = 0;

   always #2 clk = ~clk;

   i2s_tx_port #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SLOT_W(SLOT_W), .THR_W(THR_W)) i_i2s_tx_port (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .cfg_enable_i(en), .cfg_play_i(play), .cfg_dma_en_i(dma_en),
      .cfg_size_i(size), .cfg_mono_i(mono), .cfg_flush_i(flush),
      .cfg_thresh_i(thr), .cfg_replay_i(replay), .cfg_lj_i(lj),
      .cfg_svc_ie_i(svc_ie), .cfg_urun_ie_i(urun_ie),
      .bclk_fall_i(bfall), .fsync_i(fsync),
      .sdo_o(sdo), .dma_req_o(dma_req), .svc_irq_o(svc_irq),
      .urun_flag_o(urun_flag), .urun_irq_o(urun_irq), .fifo_level_o(level)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic push(input logic [DATA_W-1:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
   endtask

   // one bit-clock falling edge; checks the bit it produces and that it holds
   task automatic one_bit(input logic exp_bit, input string req);
      @(negedge clk); bfall = 1'b1; fsync = n_fall[5];
      @(negedge clk); bfall = 1'b0;
      chk(sdo == exp_bit, req, int'(sdo), int'(exp_bit));
      @(negedge clk);
      chk(sdo == exp_bit, "R11 sdo stable between strobes", int'(sdo), int'(exp_bit));
      n_fall++;
   endtask

   function automatic logic [SLOT_W-1:0] mk_word(input logic [DATA_W-1:0] s, input logic [2:0] sz);
      if (sz == 3'd0) return {s[7:0], 24'h0};
      return {s, 16'h0};
   endfunction

   function automatic logic slot_bit(input logic [SLOT_W-1:0] w, input int pos, input logic is_lj);
      if (is_lj) return w[31 - pos];
      if (pos == 0) return 1'b0;
      return w[32 - pos];
   endfunction

   // one configuration: NS samples, NSLOT slots, checked bit by bit
   task automatic run_cfg(input int idx, input logic c_lj, input logic [2:0] c_sz,
                          input logic c_mono, input logic c_rep, input int ns, input int nslot);
      logic [DATA_W-1:0] q [8];
      int qh, qn;
      logic [DATA_W-1:0] last, cur, s;
      logic uf;
      logic [SLOT_W-1:0] w;
      string rq;
      en = 1'b0; play = 1'b0;
      do_flush();
      qh = 0; qn = 0; last = '0; cur = '0; uf = 1'b0;
      for (int i = 0; i < ns; i++) begin
         q[i] = DATA_W'((idx * 16'h1111) ^ (i * 16'h3C5B) ^ 16'h8001);
         push(q[i]);
         qn++;
      end
      @(negedge clk);
      lj = c_lj; size = c_sz; mono = c_mono; replay = c_rep; urun_ie = idx[0];
      en = 1'b1; play = 1'b1;
      for (int sl = 0; sl < nslot; sl++) begin
         bit left = (sl % 2 == 0);
         if (left || !c_mono) begin
            if (qn > 0) begin
               s = q[qh]; qh++; qn--; last = s;
               rq = c_mono ? "R7 mono left" : "R6 stereo slot";
            end else begin
               uf = 1'b1;
               s = c_rep ? last : '0;
               rq = "R8 underrun data";
            end
            cur = s;
         end else begin
            s = cur;
            rq = "R7 mono right repeat";
         end
         w = mk_word(s, c_sz);
         for (int p = 0; p < 32; p++)
            one_bit(slot_bit(w, p, c_lj), $sformatf("%s R4 R5 cfg=%0d slot=%0d bit=%0d", rq, idx, sl, p));
      end
      chk(urun_flag == uf, "R8 underrun flag", int'(urun_flag), int'(uf));
      chk(urun_irq == (uf & idx[0]), "R9 underrun irq", int'(urun_irq), int'(uf & idx[0]));
      chk(level == LVL_W'(qn), "R6 level after play", int'(level), qn);
      en = 1'b0; play = 1'b0;
   endtask

   initial begin
      #400000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(level == 0, "R1 reset level", int'(level), 0);
      chk(sdo == 0, "R10 reset sdo", int'(sdo), 0);
      chk(urun_flag == 0, "R8 reset flag", int'(urun_flag), 0);
      chk(dma_req == 0, "R3 reset dma off", int'(dma_req), 0);

      // level/threshold sweep: every level against every threshold
      dma_en = 1'b1; svc_ie = 1'b1;
      for (int l = 0; l <= DEPTH; l++) begin
         if (l > 0) push(DATA_W'(l));
         chk(level == LVL_W'(l), "R1 level count", int'(level), l);
         for (int t = 0; t < 16; t++) begin
            @(negedge clk); thr = THR_W'(t);
            @(negedge clk);
            chk(dma_req == (l <= t), "R3 dma at threshold", int'(dma_req), int'(l <= t));
            chk(svc_irq == (l <= t), "R3 svc irq", int'(svc_irq), int'(l <= t));
         end
      end
      push(16'hFFFF);
      chk(level == LVL_W'(DEPTH), "R1 write when full dropped", int'(level), DEPTH);
      @(negedge clk); flush = 1'b1; wr_en = 1'b1; wr_data = 16'h1234;
      @(negedge clk); flush = 1'b0; wr_en = 1'b0;
      chk(level == 0, "R2 flush beats write", int'(level), 0);
      thr = 4'd8;
      dma_en = 1'b0; svc_ie = 1'b0;
      @(negedge clk);
      chk(dma_req == 0, "R3 dma disabled", int'(dma_req), 0);
      chk(svc_irq == 0, "R3 svc disabled", int'(svc_irq), 0);

      // global enable without playback enable: silent, nothing consumed
      push(16'hFFFF); push(16'hFFFF);
      en = 1'b1; play = 1'b0; lj = 1'b1;
      for (int p = 0; p < 64; p++) one_bit(1'b0, "R10 idle sdo");
      chk(level == 2, "R10 idle keeps fifo", int'(level), 2);
      chk(urun_flag == 0, "R10 idle no underrun", int'(urun_flag), 0);
      en = 1'b0;

      // sweep framing, width, mono and replay; 2 samples force underrun
      for (int c = 0; c < 16; c++)
         run_cfg(c, c[0], c[1] ? 3'd1 : 3'd0, c[2], c[3], 2, 6);

      // width code outside 0/1 behaves as 16-bit
      run_cfg(5, 1'b1, 3'd5, 1'b0, 1'b0, 2, 2);

      do_flush();
      chk(urun_flag == 0, "R2 flush clears underrun", int'(urun_flag), 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule